// File: doc/BRIEF.md
# Dual-View Control Register with Step Counters

This block holds one 32-bit control word that software writes and reads over a simple register bus at offset 0. A view-select input decides how that word is interpreted. In the counter view, the word is cut into four byte-wide step fields, and each field drives one free-running counter. On every clock that counter advances by the field value plus one. In the command view, the counters stop, and the same word is treated as a memory command address. The upper half is the row and the lower half is the column. A start strobe issues the address as a one-cycle command pulse.

The storage is shared by both views. Switching views never changes or clears the word, so a value written while one view is active is used as it stands by the other view. A read always returns the stored 32 bits. Bus accesses to any other offset are harmless: they read zero and write nothing.

Top module: `dual_view_ctrl`

## Requirements
- R1: After reset, the control word reads 0, all four counters are 0, and `cmd_valid` is 0.
- R2: A write with `bus_wr`=1 and `bus_addr`=0 stores all 32 bits of `bus_wdata` at that clock edge. While `bus_addr`=0, `bus_rdata` shows the stored word, and the value read does not depend on `mode_b`.
- R3: While `mode_b`=0 (counter view), counter k (k=0..3, output slice `cnt_flat[k*CNT_W +: CNT_W]`) adds (word bits [8k+7:8k]) + 1 on every clock edge. With word 0x00010001, counters 0 and 2 step by 2 and counters 1 and 3 step by 1.
- R4: Counters wrap modulo 2^CNT_W.
- R5: While `mode_b`=1 (command view), every counter holds its value.
- R6: Changing `mode_b` leaves the stored word unchanged. In the command view, row = word bits [31:16] and col = word bits [15:0], so 0x00010001 gives row 1, col 1.
- R7: In the command view, `start`=1 at a clock edge makes `cmd_valid`=1 for the following cycle, with `cmd_row` and `cmd_col` taken from the word at that edge. In the counter view, `start` produces no pulse.
- R8: A write to a nonzero `bus_addr` does not change the word, and a nonzero `bus_addr` reads 0.
- R9: A written word takes effect at the edge of the write, so counters use the new step fields from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_b | input | 1 | View select: 0 counter view, 1 command view |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| start | input | 1 | Command request strobe |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_row | output | 16 | Command row address |
| cmd_col | output | 16 | Command column address |
| cnt_flat | output | 4*CNT_W | Four counters, counter 0 in the low slice |

## Verification
The counter view is tried with four words:
- An all-zero word checks the plain count by one.
- 0x00010001 checks the alternating step pattern.
- 0x03FF0702 gives every lane a different step, so swapped or shifted byte lanes show up.
- A 0xFF field on a narrow counter forces a wrap.

In the command view, 0x1234ABCD has distinct halves, so a row/column swap is visible. The word is also written in one view and used in the other, which separates shared storage from per-view copies. A write just before a step is sampled edge by edge, which catches a step change that comes one cycle early or late.

// File: rtl/dvr_pkg.sv
package dvr_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_CTR = 4;
  localparam int FLD_W   = REG_W / NUM_CTR;
  localparam int HALF_W  = REG_W / 2;

  typedef enum logic {
    VIEW_CTR = 1'b0,
    VIEW_CMD = 1'b1
  } view_e;

  function automatic logic [FLD_W:0] dvr_step(input logic [FLD_W-1:0] fld);
    return {1'b0, fld} + {{FLD_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic [HALF_W-1:0] dvr_row(input logic [REG_W-1:0] w);
    return w[REG_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] dvr_col(input logic [REG_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/dvr_regfile.sv
module dvr_regfile
  import dvr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  ctrl_word,
  output logic              wr_hit
);
  logic addr_hit;

  assign addr_hit = (bus_addr == '0);
  assign wr_hit   = bus_wr && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_word <= '0;
    else if (wr_hit) ctrl_word <= bus_wdata;
  end

  assign bus_rdata = addr_hit ? ctrl_word : '0;
endmodule

// File: rtl/dvr_ctr_bank.sv
module dvr_ctr_bank
  import dvr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [REG_W-1:0]         ctrl_word,
  output logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
  localparam int PAD_W = CNT_W - FLD_W - 1;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
    logic [FLD_W-1:0] fld;
    logic [FLD_W:0]   step;
    logic [CNT_W-1:0] cnt_q;

    assign fld  = ctrl_word[k*FLD_W +: FLD_W];
    assign step = dvr_step(fld);

    always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + {{PAD_W{1'b0}}, step};
    end

    assign cnt_flat[k*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/dvr_cmd_out.sv
module dvr_cmd_out
  import dvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [REG_W-1:0]  ctrl_word,
  output logic              cmd_valid,
  output logic [HALF_W-1:0] cmd_row,
  output logic [HALF_W-1:0] cmd_col
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_row   <= '0;
      cmd_col   <= '0;
    end else begin
      cmd_valid <= fire;
      if (fire) begin
        cmd_row <= dvr_row(ctrl_word);
        cmd_col <= dvr_col(ctrl_word);
      end
    end
  end
endmodule

// File: rtl/dual_view_ctrl.sv
module dual_view_ctrl
  import dvr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_b,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [REG_W-1:0]         bus_wdata,
  output logic [REG_W-1:0]         bus_rdata,
  input  logic                     start,
  output logic                     cmd_valid,
  output logic [HALF_W-1:0]        cmd_row,
  output logic [HALF_W-1:0]        cmd_col,
  output logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
  view_e            view;
  logic [REG_W-1:0] ctrl_word;
  logic             wr_hit;
  logic             ctr_run;
  logic             cmd_fire;

  assign view     = view_e'(mode_b);
  assign ctr_run  = (view == VIEW_CTR);
  assign cmd_fire = (view == VIEW_CMD) && start;

  dvr_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_word(ctrl_word), .wr_hit(wr_hit)
  );

  dvr_ctr_bank #(.CNT_W(CNT_W)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .run(ctr_run),
    .ctrl_word(ctrl_word), .cnt_flat(cnt_flat)
  );

  dvr_cmd_out u_cmd (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire), .ctrl_word(ctrl_word),
    .cmd_valid(cmd_valid), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );
endmodule

// File: rtl/dual_view_ctrl_chk.sv
module dual_view_ctrl_chk
  import dvr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_b,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [REG_W-1:0]         bus_wdata,
  input logic [REG_W-1:0]         bus_rdata,
  input logic                     start,
  input logic                     cmd_valid,
  input logic [HALF_W-1:0]        cmd_row,
  input logic [HALF_W-1:0]        cmd_col,
  input logic [NUM_CTR*CNT_W-1:0] cnt_flat,
  input logic [REG_W-1:0]         ctrl_word
);
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> ctrl_word == $past(bus_wdata));

  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ctrl_word));

  a_r8_offaddr_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != '0) |=> $stable(ctrl_word));

  a_r8_offaddr_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != '0) |-> bus_rdata == '0);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode_b |=> $stable(cnt_flat));

  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b && start) |=> (cmd_valid && cmd_row == $past(ctrl_word[REG_W-1:HALF_W])
                           && cmd_col == $past(ctrl_word[HALF_W-1:0])));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_b && start) |=> !cmd_valid);

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_b |=> cnt_flat[k*CNT_W +: CNT_W] ==
        $past(cnt_flat[k*CNT_W +: CNT_W]) + CNT_W'($past(ctrl_word[k*FLD_W +: FLD_W])) + CNT_W'(1));
  end
endmodule

bind dual_view_ctrl dual_view_ctrl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start), .cmd_valid(cmd_valid),
  .cmd_row(cmd_row), .cmd_col(cmd_col), .cnt_flat(cnt_flat), .ctrl_word(ctrl_word)
);

// File: tb/dual_view_ctrl_bench.sv
`timescale 1ns/1ps
module dual_view_ctrl_bench;
  localparam int CW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_b = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          start = 1'b0;
  logic          cmd_valid;
  logic [15:0]   cmd_row, cmd_col;
  logic [4*CW-1:0] cnt_flat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_view_ctrl #(.CNT_W(CW), .ADDR_W(AW)) u_dual_view_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start), .cmd_valid(cmd_valid),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cnt_flat(cnt_flat)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cnt(input int k);
    return cnt_flat[k*CW +: CW];
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a; #0.5;
    chk(req, "read", bus_rdata, exp);
    bus_addr = '0;
  endtask

  // run n edges in counter view and compare each lane against its step field
  task automatic step_run(input string req, input logic [31:0] w, input int n);
    logic [CW-1:0] s [4];
    @(negedge clk);
    for (int k = 0; k < 4; k++) s[k] = cnt(k);
    repeat (n) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [CW-1:0] e;
      e = s[k] + CW'(n * (int'(w[k*8 +: 8]) + 1));
      chk(req, $sformatf("lane%0d delta", k), cnt(k), e);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd_chk("R1", 0, 32'h0);
    chk("R1", "cmd_valid", cmd_valid, 0);
    for (int k = 0; k < 4; k++) chk("R1", "cnt", cnt(k), 1);
  endtask

  task automatic t_rw;
    wr(0, 32'hA5C3_0F7E);
    rd_chk("R2", 0, 32'hA5C3_0F7E);
    mode_b = 1'b1;
    rd_chk("R2", 0, 32'hA5C3_0F7E);
    mode_b = 1'b0;
  endtask

  task automatic t_steps;
    wr(0, 32'h0);            step_run("R3", 32'h0, 7);
    wr(0, 32'h0001_0001);    step_run("R3", 32'h0001_0001, 9);
    wr(0, 32'h03FF_0702);    step_run("R3", 32'h03FF_0702, 5);
  endtask

  task automatic t_wrap;
    wr(0, 32'hFF00_0000);
    step_run("R4", 32'hFF00_0000, 300);
  endtask

  task automatic t_timing;
    logic [CW-1:0] c;
    wr(0, 32'h0000_0004);
    @(negedge clk);
    c = cnt(0);
    bus_wr = 1'b1; bus_addr = 0; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R9", "old step at write edge", cnt(0), c + CW'(5));
    @(negedge clk);
    chk("R9", "new step next edge", cnt(0), c + CW'(5 + 17));
  endtask

  task automatic t_mode_b;
    logic [CW-1:0] s;
    wr(0, 32'h0001_0001);
    @(negedge clk);
    mode_b = 1'b1;
    @(negedge clk);
    s = cnt(1);
    repeat (10) @(negedge clk);
    chk("R5", "hold", cnt(1), s);
    rd_chk("R6", 0, 32'h0001_0001);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "valid", cmd_valid, 1);
    chk("R6", "row", cmd_row, 16'h1);
    chk("R6", "col", cmd_col, 16'h1);
    @(negedge clk);
    chk("R7", "single pulse", cmd_valid, 0);
    wr(0, 32'h1234_ABCD);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "row", cmd_row, 16'h1234);
    chk("R7", "col", cmd_col, 16'hABCD);
    mode_b = 1'b0;
    rd_chk("R6", 0, 32'h1234_ABCD);
    step_run("R6", 32'h1234_ABCD, 4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "no pulse in counter view", cmd_valid, 0);
  endtask

  task automatic t_offaddr;
    wr(0, 32'h5555_AAAA);
    wr(4, 32'hDEAD_BEEF);
    rd_chk("R8", 0, 32'h5555_AAAA);
    rd_chk("R8", 4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_steps();
    t_wrap();
    t_timing();
    t_mode_b();
    t_offaddr();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule